// File: doc/BRIEF.md
# Twisted-Pair Link Integrity and Power-Down Sequencer

This block sequences a 10BASE-T transceiver from power-down to a qualified link. Three conditions put it into power-down: the chip's hard reset, a deep-sleep (coma) request, or the port being deselected. While any of them holds, the transmit driver enable, the status enable and the link indication are all low. A power-down cause overrides every other state in the same cycle.

When every cause clears, the block holds its internal reset for a fixed number of microseconds. It counts these with a one-microsecond clock-enable tick. It then enters link-fail. From link-fail it moves to link-pass when it has seen a set number of link beat pulses, or a single received frame.

A snooze input keeps transmit disabled. Receive-side detection carries on, so link beat pulses are still counted and the link can still qualify. Analog pulse detection happens outside the block. Here, `linkPulse` and `rxFrame` are one-cycle strobes.

Top module: `tp_link_seq`

## Requirements
- R1: While `hardRst` is 1, `comaReq` is 1 or `portSel` is 0, the outputs `linkPass`, `txDriveEn` and `statusEn` are all 0 in that same cycle, and the sequencer restarts from power-down.
- R2: During power-down and the reset hold that follows it, `linkPass`, `txDriveEn` and `statusEn` stay 0.
- R3: After all power-down causes clear, the block leaves the hold on the clock edge that samples the HOLD_US-th `usTick` pulse (default 10). Before that edge, `statusEn` is 0.
- R4: On leaving the hold, the block is in link-fail: `statusEn` is 1, `linkPass` is 0, and `txDriveEn` is 1 unless `snooze` is 1.
- R5: In link-fail, `linkPass` becomes 1 on the edge that samples the PULSE_MIN-th `linkPulse` strobe (default 5). Fewer pulses leave it 0.
- R6: In link-fail, one `rxFrame` strobe sets `linkPass` to 1 on the edge that samples it.
- R7: Pulses counted before a power-down do not carry over. After the next hold, a fresh set of PULSE_MIN pulses is needed.
- R8: While `snooze` is 1, `txDriveEn` is 0 in that same cycle. Pulse counting and `statusEn` are unaffected.
- R9: Once in link-pass, the block stays there until a power-down cause appears. Further pulses and frames have no effect on the outputs.
- R10: `linkPulse` and `rxFrame` strobes that arrive during the reset hold are ignored. They do not count towards qualification.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hardRst | input | 1 | Hard reset; a power-down cause |
| comaReq | input | 1 | Deep-sleep request; a power-down cause |
| portSel | input | 1 | Port selected; 0 is a power-down cause |
| snooze | input | 1 | Keeps transmit off while receive detection stays active |
| usTick | input | 1 | One-cycle strobe every microsecond |
| linkPulse | input | 1 | One-cycle strobe per detected link beat pulse |
| rxFrame | input | 1 | One-cycle strobe per detected received frame |
| linkPass | output | 1 | Link qualified |
| txDriveEn | output | 1 | Transmit driver enable; 0 forces the driver outputs low |
| statusEn | output | 1 | Enables the transceiver status signals |

## Verification
The assertions assume that the block is held in `hardRst` until the first clock edges have loaded its state. They also assume that `usTick`, `linkPulse` and `rxFrame` are single-cycle strobes, not held levels. The stimulus drives each strobe high for exactly one cycle on the falling edge, with a gap of random length after it. The bench applies `hardRst` from time zero and draws power-down causes, snooze settings, pulse counts and frame arrivals at random from a fixed seed. Directed cases cover carry-over of the pulse count across power-down and strobes that arrive during the hold.

// File: rtl/tp_link_pkg.sv
package tp_link_pkg;

  typedef enum logic [1:0] {
    ST_POWER_DOWN = 2'd0,
    ST_RESET_HOLD = 2'd1,
    ST_LINK_FAIL  = 2'd2,
    ST_LINK_PASS  = 2'd3
  } linkState_t;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic holdClr;
    logic holdStep;
    logic beatClr;
    logic beatStep;
  } seqStrobe_t;

endpackage

// File: rtl/tp_link_dp.sv
module tp_link_dp
  import tp_link_pkg::*;
#(
  parameter int HOLD_US   = 10,
  parameter int PULSE_MIN = 5
) (
  input  logic       clk,
  input  logic       hardRst,
  input  seqStrobe_t strb,
  output logic       holdDone,
  output logic       beatDone
);

  localparam int HOLD_W = (HOLD_US   > 1) ? $clog2(HOLD_US)   : 1;
  localparam int BEAT_W = (PULSE_MIN > 1) ? $clog2(PULSE_MIN) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_US - 1);
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(PULSE_MIN - 1);

  logic [HOLD_W-1:0] holdCnt;
  logic [BEAT_W-1:0] beatCnt;

  always_ff @(posedge clk) begin
    if (strb.holdClr)       holdCnt <= '0;
    else if (strb.holdStep) holdCnt <= holdCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.beatClr)       beatCnt <= '0;
    else if (strb.beatStep) beatCnt <= beatCnt + 1'b1;
  end

  assign holdDone = (holdCnt == HOLD_LAST);
  assign beatDone = (beatCnt == BEAT_LAST);

  // R3: the hold count never passes the last microsecond
  a_r3_hold_bound: assert property (@(posedge clk) disable iff (hardRst)
    holdCnt <= HOLD_LAST);
  // R5: the beat count never reaches the qualifying total
  a_r5_beat_bound: assert property (@(posedge clk) disable iff (hardRst)
    beatCnt <= BEAT_LAST);
  // R7: a clear leaves the beat count at zero
  a_r7_beat_cleared: assert property (@(posedge clk) disable iff (hardRst)
    strb.beatClr |=> beatCnt == '0);

endmodule

// File: rtl/tp_link_ctrl.sv
module tp_link_ctrl
  import tp_link_pkg::*;
(
  input  logic       clk,
  input  logic       hardRst,
  input  logic       comaReq,
  input  logic       portSel,
  input  logic       snooze,
  input  logic       usTick,
  input  logic       linkPulse,
  input  logic       rxFrame,
  input  logic       holdDone,
  input  logic       beatDone,
  output seqStrobe_t strb,
  output logic       linkPass,
  output logic       txDriveEn,
  output logic       statusEn
);

  linkState_t stateQ, stateNxt;
  logic pdCause, live;

  assign pdCause = hardRst | comaReq | ~portSel;

  always_comb begin
    stateNxt = stateQ;
    strb     = '0;
    if (pdCause) begin
      stateNxt     = ST_POWER_DOWN;
      strb.holdClr = 1'b1;
      strb.beatClr = 1'b1;
    end else begin
      unique case (stateQ)
        ST_POWER_DOWN: begin
          strb.holdClr = 1'b1;
          strb.beatClr = 1'b1;
          stateNxt     = ST_RESET_HOLD;
        end
        ST_RESET_HOLD: begin
          strb.beatClr = 1'b1;
          if (usTick) begin
            if (holdDone) stateNxt = ST_LINK_FAIL;
            else          strb.holdStep = 1'b1;
          end
        end
        ST_LINK_FAIL: begin
          if (rxFrame || (linkPulse && beatDone)) begin
            stateNxt     = ST_LINK_PASS;
            strb.beatClr = 1'b1;
          end else if (linkPulse) begin
            strb.beatStep = 1'b1;
          end
        end
        ST_LINK_PASS: strb.beatClr = 1'b1;
        default:      stateNxt = ST_POWER_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) stateQ <= stateNxt;

  assign live      = ~pdCause & ((stateQ == ST_LINK_FAIL) | (stateQ == ST_LINK_PASS));
  assign statusEn  = live;
  assign txDriveEn = live & ~snooze;
  assign linkPass  = ~pdCause & (stateQ == ST_LINK_PASS);

  // R1: coma or deselect puts the state in power-down next cycle
  a_r1_enter_pd: assert property (@(posedge clk) disable iff (hardRst)
    (comaReq || !portSel) |=> stateQ == ST_POWER_DOWN);
  // R3: no exit from the hold without a tick
  a_r3_needs_tick: assert property (@(posedge clk) disable iff (hardRst)
    (stateQ == ST_RESET_HOLD && !usTick) |=> stateQ != ST_LINK_FAIL);
  // R4: link-fail is reached only from the hold
  a_r4_fail_entry: assert property (@(posedge clk) disable iff (hardRst)
    $rose(stateQ == ST_LINK_FAIL) |-> $past(stateQ) == ST_RESET_HOLD);
  // R6: link-pass is reached only from link-fail on a pulse or frame
  a_r6_pass_entry: assert property (@(posedge clk) disable iff (hardRst)
    $rose(stateQ == ST_LINK_PASS) |->
      ($past(stateQ) == ST_LINK_FAIL && $past(linkPulse || rxFrame)));
  // R9: link-pass is left only for power-down
  a_r9_pass_sticky: assert property (@(posedge clk) disable iff (hardRst)
    stateQ == ST_LINK_PASS |=>
      (stateQ == ST_LINK_PASS || stateQ == ST_POWER_DOWN));

endmodule

// File: rtl/tp_link_seq.sv
module tp_link_seq
  import tp_link_pkg::*;
#(
  parameter int HOLD_US   = 10,
  parameter int PULSE_MIN = 5
) (
  input  logic clk,
  input  logic hardRst,
  input  logic comaReq,
  input  logic portSel,
  input  logic snooze,
  input  logic usTick,
  input  logic linkPulse,
  input  logic rxFrame,
  output logic linkPass,
  output logic txDriveEn,
  output logic statusEn
);

  seqStrobe_t strb;
  logic holdDone, beatDone;

  tp_link_ctrl u_ctrl (
    .clk(clk), .hardRst(hardRst), .comaReq(comaReq), .portSel(portSel),
    .snooze(snooze), .usTick(usTick), .linkPulse(linkPulse), .rxFrame(rxFrame),
    .holdDone(holdDone), .beatDone(beatDone), .strb(strb),
    .linkPass(linkPass), .txDriveEn(txDriveEn), .statusEn(statusEn)
  );

  tp_link_dp #(.HOLD_US(HOLD_US), .PULSE_MIN(PULSE_MIN)) u_dp (
    .clk(clk), .hardRst(hardRst), .strb(strb),
    .holdDone(holdDone), .beatDone(beatDone)
  );

  // R8: snooze keeps the driver off
  a_r8_snooze_tx_off: assert property (@(posedge clk) disable iff (hardRst)
    snooze |-> !txDriveEn);

endmodule

// File: tb/tb_tp_link_seq.sv
module tb_tp_link_seq;

  localparam int HOLD_US   = 10;
  localparam int PULSE_MIN = 5;

  logic clk = 1'b0;
  logic hardRst = 1'b1, comaReq = 1'b0, portSel = 1'b1, snooze = 1'b0;
  logic usTick = 1'b0, linkPulse = 1'b0, rxFrame = 1'b0;
  logic linkPass, txDriveEn, statusEn;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tp_link_seq #(.HOLD_US(HOLD_US), .PULSE_MIN(PULSE_MIN)) dut (
    .clk(clk), .hardRst(hardRst), .comaReq(comaReq), .portSel(portSel),
    .snooze(snooze), .usTick(usTick), .linkPulse(linkPulse), .rxFrame(rxFrame),
    .linkPass(linkPass), .txDriveEn(txDriveEn), .statusEn(statusEn)
  );

  function automatic bit expPass(int pulses, bit frame);
    return (pulses >= PULSE_MIN) || frame;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkOuts(string req, logic p, logic t, logic s);
    chk({req, " linkPass"}, linkPass, p);
    chk({req, " txDriveEn"}, txDriveEn, t);
    chk({req, " statusEn"}, statusEn, s);
  endtask

  task automatic gap(); repeat ($urandom % 3) @(negedge clk); endtask
  task automatic tick();  @(negedge clk) usTick = 1;    @(negedge clk) usTick = 0;    gap(); endtask
  task automatic beat();  @(negedge clk) linkPulse = 1; @(negedge clk) linkPulse = 0; gap(); endtask
  task automatic frame(); @(negedge clk) rxFrame = 1;   @(negedge clk) rxFrame = 0;   gap(); endtask

  task automatic enterPd(int cause);
    @(negedge clk);
    case (cause)
      0:       hardRst = 1;
      1:       comaReq = 1;
      default: portSel = 0;
    endcase
    #1 chkOuts("R1", 0, 0, 0);
    repeat (2) @(negedge clk);
    chkOuts("R2", 0, 0, 0);
  endtask

  // release causes and run the hold; strays exercise R10
  task automatic releaseHold(bit strays);
    @(negedge clk);
    hardRst = 0; comaReq = 0; portSel = 1;
    @(negedge clk);
    for (int i = 1; i <= HOLD_US; i++) begin
      if (i == HOLD_US) chk("R2 statusEn before last tick", statusEn, 1'b0);
      tick();
      if (strays && i < HOLD_US && ($urandom % 2)) begin
        if ($urandom % 4 == 0) frame(); else beat();
        chk("R10 linkPass during hold", linkPass, 1'b0);
      end
    end
    chk("R3 statusEn after last tick", statusEn, 1'b1);
    chkOuts("R4", 0, !snooze, 1);
  endtask

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    chkOuts("R1 reset state", 0, 0, 0);

    // directed: 4 pulses, power-down, then 4 more must not qualify (R7)
    releaseHold(0);
    repeat (PULSE_MIN - 1) beat();
    chk("R5 short pulse run", linkPass, 1'b0);
    enterPd(1);
    releaseHold(0);
    repeat (PULSE_MIN - 1) beat();
    chk("R7 count cleared by power-down", linkPass, 1'b0);
    beat();
    chk("R5 final pulse", linkPass, 1'b1);
    beat(); frame();
    chkOuts("R9 stays in pass", 1, 1, 1);
    // snooze toggles the driver immediately (R8)
    @(negedge clk) snooze = 1;
    #1 chkOuts("R8 snooze in pass", 1, 0, 1);
    @(negedge clk) snooze = 0;
    #1 chk("R8 snooze released", txDriveEn, 1'b1);

    // directed: frame alone qualifies (R6); strays in hold ignored (R10)
    enterPd(2);
    releaseHold(1);
    chk("R10 no pass after hold strays", linkPass, 1'b0);
    frame();
    chk("R6 single frame", linkPass, 1'b1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int n;
      bit fr;
      enterPd($urandom % 3);
      snooze = $urandom % 2;
      releaseHold($urandom % 2);
      n  = $urandom % 8;
      fr = ($urandom % 4) == 0;
      for (int k = 0; k < n; k++) beat();
      if (fr) frame();
      chk("R5 R6 random qualification", linkPass, expPass(n, fr));
      chk("R8 random snooze", txDriveEn, !snooze);
      chk("R8 status with snooze", statusEn, 1'b1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule